// File: doc/BRIEF.md
# Multi-Level Page Table Walker

The walker turns a 64-bit virtual address into a 52-bit physical address. It reads 64-bit table entries from memory one level at a time, starting at a root table whose frame number is given per request. The walk runs four levels deep (48-bit addresses) or five levels deep (57-bit addresses), chosen with each request. A walk ends early when an entry maps a 2 MiB or 1 GiB page. The walker reports the physical address together with a page-size code, or a fault code together with the level at which the fault arose.

Write, user and no-execute rights are combined over every entry on the path. The walker sets the accessed bit of each entry it uses, and sets the dirty bit of the leaf on a write. An entry is written back only when its value changes. Memory is reached through one request/valid port that carries either a read or a write, with at most one access outstanding. A client presents a request when `req_ready_o` is high and receives a single-cycle response.

Top module: `ptw_top`

## Requirements
- R1: The table index for level L is VA bits [12+9*(L-1) +: 9]. An entry address is the table frame times 4096 plus the index times 8. The top table frame is `req_root_i`, captured when the request is accepted. Lower table frames come from entry bits 51:12.
- R2: With `req_mode5_i`=1 the walk starts at level 5, otherwise at level 4. The mode is sampled only when the request is accepted.
- R3: In 4-level mode VA bits 63:47 must all be equal, and in 5-level mode VA bits 63:56 must all be equal. Otherwise the response carries fault 5 at the top level, and no memory access is made.
- R4: Entry bits are: 0 present, 1 writable, 2 user, 5 accessed, 6 dirty, 7 page-size, 51:12 frame, 63 no-execute. An entry with bit 0 clear gives fault 1 at that entry's level.
- R5: A level-1 entry is a 4 KiB leaf (size code 0, PA = {frame, VA[11:0]}). Bit 7 set at level 2 gives a 2 MiB leaf (size 1, PA = {entry[51:21], VA[20:0]}). Bit 7 set at level 3 gives a 1 GiB leaf (size 2, PA = {entry[51:30], VA[29:0]}). Bit 7 is ignored at levels 1, 4 and 5. A successful response has fault 0 and level = size + 1.
- R6: Access kind is 0 read, 1 write, 2 fetch. Rights are combined along the path, and the check is made at the leaf level in this priority order: a user access with user clear at any level gives fault 3; a write with writable clear at any level gives fault 2; a fetch with no-execute set at any level gives fault 4.
- R7: A non-leaf entry read with accessed clear is written back with accessed set before the next level is read. A leaf of a successful walk ends with accessed set.
- R8: A successful write access leaves the leaf with dirty set. A leaf that faults is never written.
- R9: An entry is written only when its value changes. An entry that already holds the needed status bits causes no memory write.
- R10: `mem_req_o` stays high, with address, write flag and data stable, until `mem_valid_i` is seen. Only one access is outstanding at a time.
- R11: A request is accepted only while `req_ready_o` is high. `req_valid_i` during a walk is ignored. `resp_valid_o` is a one-cycle pulse, followed by ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_va_i | input | 64 | Virtual address |
| req_kind_i | input | 2 | 0 read, 1 write, 2 fetch |
| req_user_i | input | 1 | User-level access |
| req_mode5_i | input | 1 | 1 = five-level walk |
| req_root_i | input | 40 | Frame number of the top table |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 52 | Entry byte address |
| mem_wdata_o | output | 64 | Entry write data |
| mem_rdata_i | input | 64 | Entry read data |
| mem_valid_i | input | 1 | Read data valid or write done |
| resp_valid_o | output | 1 | Response pulse |
| resp_pa_o | output | 52 | Physical address (fault 0 only) |
| resp_size_o | output | 2 | 0 4 KiB, 1 2 MiB, 2 1 GiB |
| resp_fault_o | output | 3 | 0 none, 1 not present, 2 write, 3 privilege, 4 no-execute, 5 non-canonical |
| resp_level_o | output | 3 | Leaf level or fault level |

## Verification
The rights check and the accessed/dirty update are both decided on the same returning leaf entry in the same cycle. A fault must suppress the write-back, while a pass must issue it only when the value changes. The sweep crosses every access kind and privilege with read-only, supervisor and no-execute marks placed at rotating levels. It also varies the initial accessed/dirty state of all entries. Each walk is judged by its fault code, by the exact count of memory writes, and by the leaf value left in the bench memory. A second collision, a new request arriving while a walk is in flight, is provoked mid-walk with a different address and mode, and is judged by the absence of any second response or extra read.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned B_P  = 0;
  localparam int unsigned B_W  = 1;
  localparam int unsigned B_U  = 2;
  localparam int unsigned B_A  = 5;
  localparam int unsigned B_D  = 6;
  localparam int unsigned B_PS = 7;
  localparam int unsigned B_NX = 63;

  localparam logic [1:0] K_READ  = 2'd0;
  localparam logic [1:0] K_WRITE = 2'd1;
  localparam logic [1:0] K_FETCH = 2'd2;

  localparam logic [2:0] F_NONE  = 3'd0;
  localparam logic [2:0] F_NP    = 3'd1;
  localparam logic [2:0] F_WR    = 3'd2;
  localparam logic [2:0] F_PRIV  = 3'd3;
  localparam logic [2:0] F_NX    = 3'd4;
  localparam logic [2:0] F_CANON = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_RESP} walk_st_e;
endpackage

// File: rtl/ptw_index.sv
module ptw_index #(
  parameter int unsigned VA_W   = 57,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned LEVELS = 5,
  parameter int unsigned LVL_W  = 3
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] slice [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign slice[g] = va_i[OFF_W + g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < LEVELS; k++)
      if (lvl_i == LVL_W'(k+1)) idx_o = slice[k];
  end
endmodule

// File: rtl/ptw_canon.sv
module ptw_canon #(
  parameter int unsigned HI_W  = 17,
  parameter int unsigned GAP_W = 9
) (
  input  logic [HI_W-1:0] hi_i,
  input  logic            mode5_i,
  output logic            ok_o
);
  logic [HI_W-GAP_W-1:0] hi5;
  logic ok4, ok5;

  assign hi5  = hi_i[HI_W-1:GAP_W];
  assign ok4  = (&hi_i) | ~(|hi_i);
  assign ok5  = (&hi5) | ~(|hi5);
  assign ok_o = mode5_i ? ok5 : ok4;
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
  import ptw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       upd_i,
  input  logic       w_i,
  input  logic       u_i,
  input  logic       nx_i,
  input  logic [1:0] kind_i,
  input  logic       user_i,
  output logic [2:0] fault_o
);
  logic w_acc, u_acc, nx_acc;
  logic w_eff, u_eff, nx_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_acc <= 1'b1; u_acc <= 1'b1; nx_acc <= 1'b0;
    end else if (clr_i) begin
      w_acc <= 1'b1; u_acc <= 1'b1; nx_acc <= 1'b0;
    end else if (upd_i) begin
      w_acc <= w_acc & w_i; u_acc <= u_acc & u_i; nx_acc <= nx_acc | nx_i;
    end
  end

  assign w_eff  = w_acc & w_i;
  assign u_eff  = u_acc & u_i;
  assign nx_eff = nx_acc | nx_i;

  // priority: privilege, write, execute
  always_comb begin
    fault_o = F_NONE;
    if (user_i && !u_eff)                  fault_o = F_PRIV;
    else if (kind_i == K_WRITE && !w_eff)  fault_o = F_WR;
    else if (kind_i == K_FETCH && nx_eff)  fault_o = F_NX;
  end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W  = 64,
  parameter int unsigned PA_W  = 52,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 9,
  parameter int unsigned LVL_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [VA_W-1:0]        req_va_i,
  input  logic [1:0]             req_kind_i,
  input  logic                   req_user_i,
  input  logic                   req_mode5_i,
  input  logic [PA_W-OFF_W-1:0]  req_root_i,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [PA_W-1:0]        mem_addr_o,
  output logic [63:0]            mem_wdata_o,
  input  logic [63:0]            mem_rdata_i,
  input  logic                   mem_valid_i,
  output logic                   resp_valid_o,
  output logic [PA_W-1:0]        resp_pa_o,
  output logic [1:0]             resp_size_o,
  output logic [2:0]             resp_fault_o,
  output logic [LVL_W-1:0]       resp_level_o
);
  localparam int unsigned FRM_W  = PA_W - OFF_W;
  localparam int unsigned ENT_SH = OFF_W - IDX_W;
  localparam int unsigned VA_USE = OFF_W + 5*IDX_W;
  localparam int unsigned MSB4   = OFF_W + 4*IDX_W - 1;
  localparam int unsigned MSB5   = OFF_W + 5*IDX_W - 1;
  localparam logic [LVL_W-1:0] ONE = LVL_W'(1);

  walk_st_e            st_q;
  logic [VA_USE-1:0]   va_q;
  logic [1:0]          kind_q;
  logic                user_q, leaf_q;
  logic [LVL_W-1:0]    lvl_q, flvl_q;
  logic [PA_W-1:0]     addr_q, pa_q;
  logic [FRM_W-1:0]    base_q;
  logic [63:0]         wdata_q;
  logic [1:0]          size_q;
  logic [2:0]          fault_q;

  logic                accept, canon_ok, is_leaf, rd_ok;
  logic [LVL_W-1:0]    top_lvl, idx_lvl;
  logic [VA_USE-1:0]   idx_va;
  logic [IDX_W-1:0]    idx;
  logic [FRM_W-1:0]    rd_frm;
  logic [63:0]         nl_upd, leaf_upd;
  logic [PA_W-1:0]     lomask, leaf_pa;
  logic [2:0]          perm_fault;
  logic                unused_bits;

  assign accept  = (st_q == ST_IDLE) && req_valid_i;
  assign top_lvl = req_mode5_i ? LVL_W'(5) : LVL_W'(4);
  assign idx_va  = (st_q == ST_IDLE) ? req_va_i[VA_USE-1:0] : va_q;
  assign idx_lvl = (st_q == ST_IDLE) ? top_lvl : lvl_q - ONE;
  assign rd_frm  = mem_rdata_i[PA_W-1:OFF_W];
  assign rd_ok   = (st_q == ST_READ) && mem_valid_i;
  assign is_leaf = (lvl_q == ONE) ||
                   (mem_rdata_i[B_PS] && (lvl_q == LVL_W'(2) || lvl_q == LVL_W'(3)));
  assign nl_upd   = mem_rdata_i | (64'd1 << B_A);
  assign leaf_upd = nl_upd | ((kind_q == K_WRITE) ? (64'd1 << B_D) : 64'd0);
  assign unused_bits = ^{mem_rdata_i[62:PA_W], mem_rdata_i[4:3], mem_rdata_i[OFF_W-1:8]};

  always_comb begin
    lomask = '0;
    for (int k = 0; k < 3; k++)
      if (lvl_q == LVL_W'(k+1)) lomask = (PA_W'(1) << (OFF_W + IDX_W*k)) - PA_W'(1);
  end
  assign leaf_pa = ({rd_frm, OFF_W'(0)} & ~lomask) | (va_q[PA_W-1:0] & lomask);

  ptw_index #(.VA_W(VA_USE), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(5), .LVL_W(LVL_W))
    u_index (.va_i(idx_va), .lvl_i(idx_lvl), .idx_o(idx));

  ptw_canon #(.HI_W(VA_W-MSB4), .GAP_W(MSB5-MSB4))
    u_canon (.hi_i(req_va_i[VA_W-1:MSB4]), .mode5_i(req_mode5_i), .ok_o(canon_ok));

  ptw_perm u_perm (
    .clk_i, .rst_ni,
    .clr_i  (accept),
    .upd_i  (rd_ok && mem_rdata_i[B_P] && !is_leaf),
    .w_i    (mem_rdata_i[B_W]),
    .u_i    (mem_rdata_i[B_U]),
    .nx_i   (mem_rdata_i[B_NX]),
    .kind_i (kind_q),
    .user_i (user_q),
    .fault_o(perm_fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; va_q <= '0; kind_q <= K_READ; user_q <= 1'b0;
      lvl_q <= '0; flvl_q <= '0; addr_q <= '0; pa_q <= '0; base_q <= '0;
      wdata_q <= '0; size_q <= '0; fault_q <= F_NONE; leaf_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q   <= req_va_i[VA_USE-1:0];
          kind_q <= req_kind_i;
          user_q <= req_user_i;
          pa_q   <= '0;
          size_q <= '0;
          if (!canon_ok) begin
            fault_q <= F_CANON; flvl_q <= top_lvl; st_q <= ST_RESP;
          end else begin
            lvl_q  <= top_lvl;
            addr_q <= {req_root_i, idx, ENT_SH'(0)};
            st_q   <= ST_READ;
          end
        end
        ST_READ: if (mem_valid_i) begin
          if (!mem_rdata_i[B_P]) begin
            fault_q <= F_NP; flvl_q <= lvl_q; st_q <= ST_RESP;
          end else if (!is_leaf) begin
            base_q <= rd_frm;
            if (!mem_rdata_i[B_A]) begin
              wdata_q <= nl_upd; leaf_q <= 1'b0; st_q <= ST_WRITE;
            end else begin
              lvl_q  <= lvl_q - ONE;
              addr_q <= {rd_frm, idx, ENT_SH'(0)};
            end
          end else begin
            flvl_q  <= lvl_q;
            fault_q <= perm_fault;
            if (perm_fault != F_NONE) begin
              st_q <= ST_RESP;
            end else begin
              pa_q   <= leaf_pa;
              size_q <= 2'(lvl_q - ONE);
              if (leaf_upd != mem_rdata_i) begin
                wdata_q <= leaf_upd; leaf_q <= 1'b1; st_q <= ST_WRITE;
              end else begin
                st_q <= ST_RESP;
              end
            end
          end
        end
        ST_WRITE: if (mem_valid_i) begin
          if (leaf_q) begin
            st_q <= ST_RESP;
          end else begin
            lvl_q  <= lvl_q - ONE;
            addr_q <= {base_q, idx, ENT_SH'(0)};
            st_q   <= ST_READ;
          end
        end
        ST_RESP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (st_q == ST_IDLE);
  assign mem_req_o    = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign mem_we_o     = (st_q == ST_WRITE);
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = wdata_q;
  assign resp_valid_o = (st_q == ST_RESP);
  assign resp_pa_o    = pa_q;
  assign resp_size_o  = size_q;
  assign resp_fault_o = fault_q;
  assign resp_level_o = flvl_q;

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                     $stable(mem_we_o) && $stable(mem_wdata_o)));
  assert_wb_accessed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_wdata_o[B_A]);
  assert_leaf_dirty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && leaf_q && kind_q == K_WRITE) |-> mem_wdata_o[B_D]);
  assert_resp_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> (!resp_valid_o && req_ready_o));
  assert_size_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_fault_o == F_NONE) |-> (resp_level_o == LVL_W'(resp_size_o) + ONE));
  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o);
endmodule

// File: tb/sim_ptw_top.sv
module sim_ptw_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] P = 64'h1, W = 64'h2, U = 64'h4, A = 64'h20, D = 64'h40, PS = 64'h80;
  localparam logic [63:0] NX = 64'h8000_0000_0000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 0, req_ready, req_user = 0, req_mode5 = 0;
  logic [63:0] req_va = 0;
  logic [1:0]  req_kind = 0;
  logic [39:0] req_root = 0;
  logic        mem_req, mem_we, resp_valid;
  logic [51:0] mem_addr, resp_pa;
  logic [63:0] mem_wdata, mem_rdata;
  logic        mem_valid;
  logic [1:0]  resp_size;
  logic [2:0]  resp_fault, resp_level;

  ptw_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_va_i(req_va), .req_kind_i(req_kind), .req_user_i(req_user), .req_mode5_i(req_mode5),
    .req_root_i(req_root), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_valid_i(mem_valid),
    .resp_valid_o(resp_valid), .resp_pa_o(resp_pa), .resp_size_o(resp_size),
    .resp_fault_o(resp_fault), .resp_level_o(resp_level)
  );

  logic [63:0] mem [longint];
  int n_rd, n_wr, n_cmp = 0, n_bad = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_valid <= 1'b0;
    else if (mem_req && !mem_valid) begin
      mem_valid <= 1'b1;
      if (mem_we) begin mem[longint'(mem_addr)] = mem_wdata; n_wr++; end
      else begin
        mem_rdata <= mem.exists(longint'(mem_addr)) ? mem[longint'(mem_addr)] : 64'd0;
        n_rd++;
      end
    end else mem_valid <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] tbl(input int l);
    return 40'h100 + 40'(l*3);
  endfunction
  function automatic logic [63:0] ent_addr(input logic [39:0] frm, input logic [63:0] va, input int l);
    logic [63:0] ix;
    ix = (va >> (12 + 9*(l-1))) & 64'd511;
    return ({24'd0, frm} << 12) | (ix << 3);
  endfunction

  logic [63:0] leaf_a, leaf_o, top_a;
  logic [2:0]  g_f, g_l;
  logic [51:0] g_pa;
  logic [1:0]  g_sz;
  bit          g_got;

  task automatic build(input logic [63:0] va, input int depth, input int leafl, input int perm,
                       input int pre, input bit noise, input int np, input int ctr,
                       input logic [39:0] frame);
    int n, wl, ul, xl;
    logic [63:0] e, a;
    n  = depth - leafl + 1;
    wl = leafl + (ctr % n); ul = leafl + ((ctr+1) % n); xl = leafl + ((ctr+2) % n);
    mem.delete();
    for (int l = depth; l >= leafl; l--) begin
      a = ent_addr(tbl(l), va, l);
      e = P | W | U;
      if (pre > 0) e |= A;
      if (l == leafl) begin
        e |= {24'd0, frame} << 12;
        if (pre == 2) e |= D;
        if (l > 1 || noise) e |= PS;
        leaf_a = a;
      end else begin
        e |= {24'd0, tbl(l-1)} << 12;
        if (noise && l >= 4) e |= PS;
      end
      if (perm[0] && l == wl) e &= ~W;
      if (perm[1] && l == ul) e &= ~U;
      if (perm[2] && l == xl) e |= NX;
      if (l == np) e &= ~P;
      mem[longint'(a)] = e;
      if (l == depth) top_a = a;
    end
    leaf_o = mem[longint'(leaf_a)];
  endtask

  task automatic walk(input logic [63:0] va, input logic [1:0] kind, input bit user,
                      input bit m5, input bit inject);
    int t, rd0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    n_rd = 0; n_wr = 0;
    req_va = va; req_kind = kind; req_user = user; req_mode5 = m5;
    req_root = tbl(m5 ? 5 : 4); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0; g_got = 0;
    while (!g_got && t < 200) begin
      if (resp_valid) begin
        g_got = 1; g_f = resp_fault; g_l = resp_level; g_pa = resp_pa; g_sz = resp_size;
      end else begin
        if (inject && t == 2) begin
          req_valid = 1'b1; req_va = ~va; req_mode5 = ~m5; req_kind = 2'd1;
        end else begin
          req_valid = 1'b0; req_mode5 = m5;
        end
        @(negedge clk); t++;
      end
    end
    req_valid = 1'b0;
    if (inject) begin
      rd0 = n_rd;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        chk(!resp_valid, "R11 no response for busy request", 64'(resp_valid), 0);
        if (resp_valid) break;
      end
      chk(n_rd == rd0 && req_ready, "R11 busy request ignored", 64'(n_rd), 64'(rd0));
    end
    chk(g_got, "R11 response arrives", 64'(g_got), 1);
  endtask

  function automatic logic [63:0] canon(input logic [63:0] v, input int msb);
    logic [63:0] hi;
    hi = ~((64'd1 << msb) - 64'd1);
    return v[msb] ? (v | hi) : (v & ~hi);
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] s, va, lomask, exp_pa, exp_leaf;
    logic [39:0] frame;
    int depth, leafl, ctr, ef, ewr;
    s = 64'h1234_5678_9abc_def1;
    ctr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req, "R11 reset idle", {61'd0, req_ready, resp_valid, mem_req}, 64'h4);

    // sweep: mode x size x kind x privilege x rights x initial status
    for (int m5 = 0; m5 < 2; m5++)
      for (int sz = 0; sz < 3; sz++)
        for (int kind = 0; kind < 3; kind++)
          for (int usr = 0; usr < 2; usr++)
            for (int perm = 0; perm < 8; perm++)
              for (int pre = 0; pre < 3; pre++) begin
                s = s * 64'd6364136223846793005 + 64'd1442695040888963407;
                depth = m5 ? 5 : 4; leafl = sz + 1;
                va = canon(s, m5 ? 56 : 47);
                frame = s[59:20];
                build(va, depth, leafl, perm, pre, s[3], 0, ctr, frame);
                walk(va, 2'(kind), usr[0], m5[0], (ctr % 7) == 0);
                ef = (usr == 1 && perm[1]) ? 3 : (kind == 1 && perm[0]) ? 2 : (kind == 2 && perm[2]) ? 4 : 0;
                chk(g_f == 3'(ef), "R6 fault code", 64'(g_f), 64'(ef));
                chk(g_l == 3'(leafl), "R5 leaf level", 64'(g_l), 64'(leafl));
                if (ef == 0) begin
                  lomask = (64'd1 << (12 + 9*sz)) - 64'd1;
                  exp_pa = ((({24'd0, frame} << 12) & ~lomask) | (va & lomask)) & 64'h000F_FFFF_FFFF_FFFF;
                  chk(g_pa == exp_pa[51:0], "R5 physical address", 64'(g_pa), exp_pa);
                  chk(g_sz == 2'(sz), "R5 size code", 64'(g_sz), 64'(sz));
                end
                chk(n_rd == depth - leafl + 1, "R1 read count", 64'(n_rd), 64'(depth - leafl + 1));
                ewr = (pre == 0 ? depth - leafl : 0) + ((ef == 0 && (pre == 0 || (kind == 1 && pre == 1))) ? 1 : 0);
                chk(n_wr == ewr, "R9 write count", 64'(n_wr), 64'(ewr));
                exp_leaf = (ef != 0) ? leaf_o : (leaf_o | A | (kind == 1 ? D : 64'd0));
                chk(mem[longint'(leaf_a)] == exp_leaf, "R8 leaf status bits", mem[longint'(leaf_a)], exp_leaf);
                chk(mem[longint'(top_a)][5], "R7 top entry accessed", mem[longint'(top_a)], 64'(A));
                ctr++;
              end

    // not-present at each level of a 5-level walk
    for (int np = 1; np <= 5; np++) begin
      va = canon(64'h0123_4567_89AB_CDEF + 64'(np), 56);
      build(va, 5, 1, 0, 0, 1'b0, np, 0, 40'h55555);
      walk(va, 2'd0, 1'b0, 1'b1, 1'b0);
      chk(g_f == 3'd1, "R4 not-present code", 64'(g_f), 1);
      chk(g_l == 3'(np), "R4 not-present level", 64'(g_l), 64'(np));
      chk(n_rd == 6 - np, "R4 reads stop at fault", 64'(n_rd), 64'(6 - np));
      chk(n_wr == 5 - np, "R7 writes above fault", 64'(n_wr), 64'(5 - np));
    end

    // canonical form
    for (int m5 = 0; m5 < 2; m5++) begin
      mem.delete();
      va = canon(64'h00AB_CDEF_0123_4567, m5 ? 56 : 47) ^ 64'h8000_0000_0000_0000;
      walk(va, 2'd0, 1'b0, m5[0], 1'b0);
      chk(g_f == 3'd5, "R3 non-canonical code", 64'(g_f), 5);
      chk(g_l == 3'(m5 ? 5 : 4), "R3 top level reported", 64'(g_l), 64'(m5 ? 5 : 4));
      chk(n_rd == 0 && n_wr == 0, "R3 no memory access", 64'(n_rd + n_wr), 0);
    end
    mem.delete();
    va = 64'h0001_0000_0000_0000;
    walk(va, 2'd0, 1'b0, 1'b0, 1'b0);
    chk(g_f == 3'd5, "R3 bit 48 set in 4-level mode", 64'(g_f), 5);
    walk(va, 2'd0, 1'b0, 1'b1, 1'b0);
    chk(g_f == 3'd1 && g_l == 3'd5, "R2 5-level accepts bit 48", {g_f, g_l}, {3'd1, 3'd5});
    chk(n_rd == 1, "R2 walk begins at level 5", 64'(n_rd), 1);

    finish_run();
  end
endmodule